// File: doc/BRIEF.md
# Stereo Serial Audio Bus Controller (Transmit and Receive)

This block drives a three-wire stereo audio link as the clock owner. It produces the bit clock and the channel-select line itself, serialises outgoing samples onto one data line, and on the same frame timing collects the bits arriving on a second data line. Outgoing data comes from a 32-bit word FIFO that the block pops. Each collected 32-bit word is written into an output FIFO. Words are treated as a raw bit stream, so a 16-bit sample depth places two samples in every word.

A free-running tick divider sets the pace. Each bit cell uses two ticks: the bit clock is low in the first tick and high in the second. Outgoing bits change as the low tick starts, and incoming bits are sampled as the low tick ends. The sample depth is a run-time input holding depth minus two. It is read whenever a channel begins. The channel-select line moves one bit early, during the last bit of the channel that is ending.

The frame sequencer has five states. IDLE holds clock high and select low. It goes to LEFT_LO on the first tick after enable. LEFT_LO always goes to LEFT_HI. LEFT_HI goes back to LEFT_LO while bits remain, or to RIGHT_LO after the last left bit. RIGHT_LO goes to RIGHT_HI. RIGHT_HI returns to RIGHT_LO, or to LEFT_LO after the last right bit. Deasserting enable returns any state to IDLE.

Top module: `i2s_xcvr`

## Requirements
- R1: While reset is held, and on the clock after enable is sampled low, sck is 1 and ws is 0. sd_out, tx_pop and rx_valid are 0. After reset, underrun and overflow are 0.
- R2: A tick occurs every div_ratio+1 clocks while enabled, counting from the clock that samples enable high. Each bit cell is one tick with sck low followed by one tick with sck high. sck changes only on the clock after a tick.
- R3: ws is 0 for left-channel bits and 1 for right-channel bits. Exception: during the final bit of a channel, ws already shows the next channel, so it changes only at the start of an sck-low half.
- R4: Each channel carries depth_m2+2 bits, for depth_m2 from 0 to 30. depth_m2 is read when a channel starts. One full frame therefore lasts 4*(depth_m2+2)*(div_ratio+1) clocks.
- R5: Transmit words are sent MSB first. When no bits of the current word are left at the start of a bit cell, the block takes tx_data in that cell. It pulses tx_pop in the same clock as the tick, and only when tx_valid is 1.
- R6: If tx_valid is 0 when a new word is needed, sd_out is 0 for that bit cell and the sticky underrun flag sets. Frame timing continues, and the block tries again at the next bit cell.
- R7: sd_in is sampled on the tick that ends each sck-low half and shifted in at the LSB end. On the clock after the 32nd sample, rx_valid is 1 for one cycle, with the collected word on rx_data. The first sampled bit is at bit 31.
- R8: If rx_full is 1 when a word completes, the word is not written and the sticky overflow flag sets. Collection continues with the next word.
- R9: Clearing enable discards the unsent bits of the current word and any partly collected receive word. A later enable starts again with the left channel, a fresh word and a fresh depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the frame; low forces IDLE |
| div_ratio | input | 8 | Tick every div_ratio+1 clocks |
| depth_m2 | input | 5 | Sample depth minus two |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | Take the head transmit word this clock |
| sd_in | input | 1 | Serial data from the bus |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| rx_data | output | 32 | Last collected word |
| rx_valid | output | 1 | Write rx_data into the receive FIFO |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Channel select (0 left, 1 right) |
| sd_out | output | 1 | Serial data to the bus |
| underrun | output | 1 | Sticky: a word was needed while the FIFO was empty |
| overflow | output | 1 | Sticky: a word was dropped because the FIFO was full |

## Verification
The assertions assume that tx_valid and tx_data hold steady between clock edges, and that rx_full and sd_in are ordinary synchronous inputs. They also assume that div_ratio and depth_m2 change only while enable is low, or in the case of depth_m2, that a change is meant to apply at the next channel. The stimulus drives every input just after the falling clock edge. It changes the divider only while disabled. It presents FIFO contents from a queue that empties only when the block pops, so tx_pop can never race the data it takes.

// File: rtl/i2s_xcvr_pkg.sv
package i2s_xcvr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEFT_LO,
        ST_LEFT_HI,
        ST_RIGHT_LO,
        ST_RIGHT_HI
    } frame_state_t;
endpackage

// File: rtl/i2s_tick_gen.sv
module i2s_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;

    assign tick = run && (div_cnt == div_ratio);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_cnt <= '0;
        else if (!run)   div_cnt <= '0;
        else if (tick)   div_cnt <= '0;
        else             div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/i2s_frame_fsm.sv
module i2s_frame_fsm
    import i2s_xcvr_pkg::*;
#(
    parameter int DEP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DEP_W-1:0] depth_m2,
    output logic             drive_evt,
    output logic             sample_evt,
    output logic             sck,
    output logic             ws
);
    frame_state_t     state, state_nxt;
    logic [DEP_W-1:0] bits_left;
    logic             last_bit;
    logic [DEP_W-1:0] reload;

    assign last_bit = (bits_left == '0);
    assign reload   = depth_m2 + DEP_W'(1);

    // next state and event strobes
    always_comb begin
        state_nxt  = state;
        drive_evt  = 1'b0;
        sample_evt = 1'b0;
        if (!run) begin
            state_nxt = ST_IDLE;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_LEFT_LO;
                    drive_evt = 1'b1;
                end
                ST_LEFT_LO: begin
                    state_nxt  = ST_LEFT_HI;
                    sample_evt = 1'b1;
                end
                ST_LEFT_HI: begin
                    state_nxt = last_bit ? ST_RIGHT_LO : ST_LEFT_LO;
                    drive_evt = 1'b1;
                end
                ST_RIGHT_LO: begin
                    state_nxt  = ST_RIGHT_HI;
                    sample_evt = 1'b1;
                end
                ST_RIGHT_HI: begin
                    state_nxt = last_bit ? ST_LEFT_LO : ST_RIGHT_LO;
                    drive_evt = 1'b1;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register and per-channel bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bits_left <= '0;
        end else begin
            state <= state_nxt;
            if (!run) begin
                bits_left <= '0;
            end else if (tick) begin
                if (state == ST_IDLE || ((state == ST_LEFT_HI || state == ST_RIGHT_HI) && last_bit))
                    bits_left <= reload;
                else if (state == ST_LEFT_HI || state == ST_RIGHT_HI)
                    bits_left <= bits_left - 1'b1;
            end
        end
    end

    // bus outputs decoded from state
    always_comb begin
        unique case (state)
            ST_LEFT_LO:  begin sck = 1'b0; ws = last_bit;  end
            ST_LEFT_HI:  begin sck = 1'b1; ws = last_bit;  end
            ST_RIGHT_LO: begin sck = 1'b0; ws = !last_bit; end
            ST_RIGHT_HI: begin sck = 1'b1; ws = !last_bit; end
            default:     begin sck = 1'b1; ws = 1'b0;      end
        endcase
    end
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              drive_evt,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              sd_out,
    output logic              underrun
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  left;
    logic              need_word;

    assign need_word = (left == '0);
    assign tx_pop    = drive_evt && need_word && tx_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            left     <= '0;
            sd_out   <= 1'b0;
            underrun <= 1'b0;
        end else if (!run) begin
            left   <= '0;
            sd_out <= 1'b0;
        end else if (drive_evt) begin
            if (!need_word) begin
                sd_out <= shreg[WORD_W-1];
                shreg  <= {shreg[WORD_W-2:0], 1'b0};
                left   <= left - 1'b1;
            end else if (tx_valid) begin
                sd_out <= tx_data[WORD_W-1];
                shreg  <= {tx_data[WORD_W-2:0], 1'b0};
                left   <= CNT_W'(WORD_W - 1);
            end else begin
                sd_out   <= 1'b0;
                underrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2s_rx_packer.sv
module i2s_rx_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sample_evt,
    input  logic              sd_in,
    input  logic              rx_full,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              overflow
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] word_nxt;
    logic [CNT_W-1:0]  count;

    assign word_nxt = {shreg[WORD_W-2:0], sd_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            count    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            overflow <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!run) begin
                count <= '0;
            end else if (sample_evt) begin
                shreg <= word_nxt;
                if (count == CNT_W'(WORD_W - 1)) begin
                    count <= '0;
                    if (!rx_full) begin
                        rx_data  <= word_nxt;
                        rx_valid <= 1'b1;
                    end else begin
                        overflow <= 1'b1;
                    end
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2s_xcvr.sv
module i2s_xcvr #(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 8,
    parameter int DEP_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [DEP_W-1:0]  depth_m2,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_pop,
    input  logic              sd_in,
    input  logic              rx_full,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sck,
    output logic              ws,
    output logic              sd_out,
    output logic              underrun,
    output logic              overflow
);
    logic tick;
    logic drive_evt;
    logic sample_evt;

    i2s_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(enable),
        .div_ratio(div_ratio), .tick(tick)
    );

    i2s_frame_fsm #(.DEP_W(DEP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick),
        .depth_m2(depth_m2), .drive_evt(drive_evt),
        .sample_evt(sample_evt), .sck(sck), .ws(ws)
    );

    i2s_tx_shifter #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(enable), .drive_evt(drive_evt),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .sd_out(sd_out), .underrun(underrun)
    );

    i2s_rx_packer #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(enable), .sample_evt(sample_evt),
        .sd_in(sd_in), .rx_full(rx_full), .rx_data(rx_data),
        .rx_valid(rx_valid), .overflow(overflow)
    );
endmodule

// File: rtl/i2s_xcvr_chk.sv
module i2s_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tick,
    input logic sck,
    input logic ws,
    input logic sd_out,
    input logic tx_valid,
    input logic tx_pop,
    input logic rx_valid,
    input logic underrun,
    input logic overflow
);
    // R1
    idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (sck && !ws && !sd_out));

    // R2
    sck_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck) && enable && $past(enable)) |-> $past(tick));

    // R3
    ws_moves_in_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ws) && $past(enable)) |-> !sck);

    // R5
    pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);

    // R5
    pop_starts_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !sck);

    // R6
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    // R7
    rx_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    no_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind i2s_xcvr i2s_xcvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .sck(sck), .ws(ws), .sd_out(sd_out), .tx_valid(tx_valid),
    .tx_pop(tx_pop), .rx_valid(rx_valid), .underrun(underrun),
    .overflow(overflow)
);

// File: tb/i2s_xcvr_test.sv
`timescale 1ns/1ps
module i2s_xcvr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_r = 1'b0;
    logic [7:0]  div_r = 8'd0;
    logic [4:0]  dm2_r = 5'd14;
    logic [31:0] txd_r = 32'd0;
    logic        txv_r = 1'b0;
    logic        sdin_r = 1'b0;
    logic        full_r = 1'b0;

    logic [31:0] rx_data;
    logic        tx_pop, rx_valid, sck, ws, sd_out, underrun, overflow;

    always #2 clk = ~clk;

    i2s_xcvr uut (
        .clk(clk), .rst_n(rst_n), .enable(en_r), .div_ratio(div_r),
        .depth_m2(dm2_r), .tx_data(txd_r), .tx_valid(txv_r), .tx_pop(tx_pop),
        .sd_in(sdin_r), .rx_full(full_r), .rx_data(rx_data), .rx_valid(rx_valid),
        .sck(sck), .ws(ws), .sd_out(sd_out), .underrun(underrun), .overflow(overflow)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // transmit FIFO contents and input drive
    logic [31:0] q[$];
    bit          feed = 0;
    logic [31:0] wgen = 32'hA5C3_0F81;
    logic [31:0] lfsr = 32'h1234_5679;

    always @(negedge clk) begin
        if (feed && q.size() < 2) begin
            q.push_back(wgen);
            wgen = wgen * 32'h0019_660D + 32'h3C6E_F35F;
        end
        txv_r  = (q.size() > 0);
        txd_r  = (q.size() > 0) ? q[0] : 32'd0;
        lfsr   = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        sdin_r = lfsr[5];
    end

    // behavioural reference: phase 0 idle, 1 clock-low half, 2 clock-high half
    int          m_st = 0, m_ch = 0, m_rem = 0, m_div = 0, m_txn = 0, m_rxn = 0;
    logic [31:0] m_tsr = 0, m_rsr = 0, m_rw = 0;
    logic        m_sd = 0, m_und = 0, m_ovf = 0, m_rv = 0;

    task automatic next_out_bit();
        if (m_txn == 0) begin
            if (txv_r) begin
                m_sd  = txd_r[31];
                m_tsr = txd_r << 1;
                m_txn = 31;
                void'(q.pop_front());
            end else begin
                m_sd  = 1'b0;
                m_und = 1'b1;
            end
        end else begin
            m_sd  = m_tsr[31];
            m_tsr = m_tsr << 1;
            m_txn--;
        end
    endtask

    always @(posedge clk) begin
        bit tk;
        if (!rst_n) begin
            m_st = 0; m_ch = 0; m_rem = 0; m_div = 0; m_txn = 0; m_rxn = 0;
            m_tsr = 0; m_rsr = 0; m_rw = 0; m_sd = 0; m_und = 0; m_ovf = 0; m_rv = 0;
        end else begin
            tk   = en_r && (m_div == int'(div_r));
            m_rv = 1'b0;
            if (!en_r || tk) m_div = 0;
            else             m_div++;
            if (!en_r) begin
                m_st = 0; m_ch = 0; m_rem = 0; m_txn = 0; m_rxn = 0; m_sd = 0;
            end else if (tk) begin
                if (m_st == 0) begin
                    m_st = 1; m_ch = 0; m_rem = int'(dm2_r) + 1;
                    next_out_bit();
                end else if (m_st == 1) begin
                    m_st  = 2;
                    m_rsr = {m_rsr[30:0], sdin_r};
                    m_rxn++;
                    if (m_rxn == 32) begin
                        m_rxn = 0;
                        if (!full_r) begin m_rw = m_rsr; m_rv = 1'b1; end
                        else m_ovf = 1'b1;
                    end
                end else begin
                    if (m_rem == 0) begin m_ch = 1 - m_ch; m_rem = int'(dm2_r) + 1; end
                    else m_rem--;
                    m_st = 1;
                    next_out_bit();
                end
            end
        end
    end

    // compare every clock, away from the rising edge
    always @(negedge clk) begin
        logic e_ws, e_pop;
        #1;
        e_ws  = (m_st == 0) ? 1'b0 : ((m_ch == 0) ? (m_rem == 0) : (m_rem != 0));
        e_pop = en_r && (m_div == int'(div_r)) && (m_st != 1) && (m_txn == 0) && txv_r;
        chk("R2 sck", {31'd0, sck}, {31'd0, (m_st != 1)});
        chk("R3 ws", {31'd0, ws}, {31'd0, e_ws});
        chk("R5 sd_out", {31'd0, sd_out}, {31'd0, m_sd});
        chk("R5 tx_pop", {31'd0, tx_pop}, {31'd0, e_pop});
        chk("R7 rx_valid", {31'd0, rx_valid}, {31'd0, m_rv});
        chk("R7 rx_data", rx_data, m_rw);
        chk("R6 underrun", {31'd0, underrun}, {31'd0, m_und});
        chk("R8 overflow", {31'd0, overflow}, {31'd0, m_ovf});
    end

    task automatic frame_len(input int exp, input string tag);
        logic p;
        int   c;
        @(negedge clk); p = ws;
        while (!(ws && !p)) begin p = ws; @(negedge clk); end
        c = 0;
        while (1) begin
            p = ws;
            @(negedge clk);
            c++;
            if (ws && !p) break;
        end
        chk(tag, c, exp);
    endtask

    task automatic go_idle();
        @(negedge clk); en_r = 1'b0;
        repeat (2) @(negedge clk);
        // R9: frame halted, bus idle
        chk("R9 idle sck", {31'd0, sck}, 32'd1);
        chk("R9 idle ws", {31'd0, ws}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 sck", {31'd0, sck}, 32'd1);
        chk("R1 ws", {31'd0, ws}, 32'd0);
        chk("R1 flags", {30'd0, underrun, overflow}, 32'd0);
        rst_n = 1'b1;
        // six words, then the FIFO runs dry: R5 then R6
        for (int i = 0; i < 6; i++) q.push_back(32'hF00D_0000 + 32'(i * 32'h1111));
        @(negedge clk); div_r = 8'd0; dm2_r = 5'd14; en_r = 1'b1;
        repeat (600) @(negedge clk);
        chk("R6 underrun seen", {31'd0, underrun}, 32'd1);
        go_idle();
        // R4: 24-bit depth, divider 1 -> 4*24*2 clocks per frame
        feed = 1; div_r = 8'd1; dm2_r = 5'd22;
        @(negedge clk); en_r = 1'b1;
        frame_len(192, "R4 frame 24b");
        repeat (300) @(negedge clk);
        go_idle();
        // R8: 32-bit depth, divider 2, receive FIFO full for a while
        div_r = 8'd2; dm2_r = 5'd30;
        @(negedge clk); en_r = 1'b1;
        frame_len(384, "R4 frame 32b");
        full_r = 1'b1;
        repeat (500) @(negedge clk);
        chk("R8 overflow seen", {31'd0, overflow}, 32'd1);
        full_r = 1'b0;
        repeat (400) @(negedge clk);
        go_idle();
        // shortest depth, two bits per channel
        div_r = 8'd0; dm2_r = 5'd0;
        @(negedge clk); en_r = 1'b1;
        frame_len(8, "R4 frame 2b");
        repeat (200) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired, run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule